// File: doc/BRIEF.md
# Supply and Watchdog Reset Supervisor

This block drives the active-low system reset for a processor subsystem. Three events can pull the reset: a low-supply indication from an external comparator, a violation of a window watchdog, and a manual reset button that is synchronised and debounced first. Once every source has gone away, the reset stays asserted for a fixed number of ticks so that clocks and supplies can settle. The same hold applies out of power-on.

The watchdog is a window timer. It has two 5-bit fields. The start field is in units of 25 ticks and sets the earliest time at which a restart is allowed. The end field is in units of 60 ticks and sets the timeout. The host restarts the timer with a one-cycle kick strobe. A kick that comes before the window opens is a violation. No kick before the window closes is also a violation. A single flag records whether the most recent reset came from the watchdog. The host can clear it.

The time base is a one-cycle tick enable, nominally at 1 kHz, so with the default parameters one tick is 1 ms.

Top module: `sup_reset_wdt`

## Requirements
- R1: After `rst_ni` is released, `sys_rst_no` is low and `wdt_flag_o` is 0. `sys_rst_no` goes high after exactly HOLD_TICKS (100) ticks, when no source is active.
- R2: `sys_rst_no` is low from the cycle after `low_vdd_i` is seen high, and stays low while `low_vdd_i` stays high.
- R3: After the last active source clears, `sys_rst_no` stays low for exactly HOLD_TICKS ticks, then goes high.
- R4: `man_rst_ni` is taken through a 2-stage synchroniser. It causes reset only after staying low for DEB_TICKS (10) consecutive ticks. A low pulse of fewer ticks has no effect.
- R5: With the watchdog armed, if no kick arrives within `wdt_end_i`×60 ticks of the window start, a reset is raised.
- R6: A kick that comes before `wdt_start_i`×25 ticks have elapsed since the window start raises a reset.
- R7: A kick at or after `wdt_start_i`×25 ticks and before the timeout restarts the window and causes no reset.
- R8: The watchdog never raises a reset when `wdt_en_i` is 0 or `wdt_end_i` is 0.
- R9: `wdt_flag_o` is set to 1 by a watchdog reset. It is cleared to 0 by a supply reset, by a manual reset, or by `flag_clr_i`. If both happen in the same cycle, the watchdog setting wins.
- R10: The watchdog count is held at zero while reset is asserted, so a full window starts when reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| tick_i | input | 1 | Time-base enable, one cycle per tick |
| low_vdd_i | input | 1 | Low-supply indication, active high |
| man_rst_ni | input | 1 | Raw manual reset button, active low |
| wdt_en_i | input | 1 | Watchdog enable |
| wdt_start_i | input | 5 | Earliest-restart time, in units of 25 ticks |
| wdt_end_i | input | 5 | Timeout, in units of 60 ticks; 0 disables the watchdog |
| kick_i | input | 1 | Watchdog restart strobe |
| flag_clr_i | input | 1 | Clears the watchdog-cause flag |
| sys_rst_no | output | 1 | System reset, active low |
| wdt_flag_o | output | 1 | 1 when the last reset came from the watchdog |

## Verification
The hardest point to reach from the ports is a kick that lands exactly at a known count inside the window. The watchdog count can only be made known by forcing a fresh window. So each trial first pulses the low-supply input and waits out the hold, which zeroes the count at a known tick. The trial then issues a set number of ticks before the kick, with the window bounds and the kick time drawn at random around both edges of the window. The expected reset and flag values are predicted from the two limits.

// File: rtl/sup_pkg.sv
package sup_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE,
    CAUSE_SUPPLY,
    CAUSE_MANUAL,
    CAUSE_WDT
  } rst_cause_e;
endpackage

// File: rtl/sup_debounce.sv
module sup_debounce #(
  parameter int DEB_TICKS   = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic raw_ni,
  output logic act_o
);
  localparam int DW = $clog2(DEB_TICKS + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [DW-1:0]          cnt_q;
  logic                   act_q;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= raw_ni;
    end else begin : g_syncn
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= {sync_q[SYNC_STAGES-2:0], raw_ni};
    end
  endgenerate

  // consecutive low ticks required; any high sample restarts the filter
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (sync_q[SYNC_STAGES-1]) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (tick_i && !act_q) begin
      if (cnt_q == DW'(DEB_TICKS - 1)) act_q <= 1'b1;
      else                             cnt_q <= cnt_q + 1'b1;
    end
  end

  assign act_o = act_q;
endmodule

// File: rtl/sup_wdt.sv
module sup_wdt #(
  parameter int START_UNIT = 25,
  parameter int END_UNIT   = 60,
  parameter int FIELD_W    = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               hold_i,
  input  logic               en_i,
  input  logic [FIELD_W-1:0] start_i,
  input  logic [FIELD_W-1:0] end_i,
  input  logic               kick_i,
  output logic               viol_o
);
  localparam int FMAX  = (1 << FIELD_W) - 1;
  localparam int LIM_S = FMAX * START_UNIT;
  localparam int LIM_E = FMAX * END_UNIT;
  localparam int LIM   = (LIM_S > LIM_E) ? LIM_S : LIM_E;
  localparam int CW    = $clog2(LIM + 1);

  logic [CW-1:0] cnt_q, start_lim, end_lim;
  logic          armed, viol_q;

  assign start_lim = CW'(start_i) * CW'(START_UNIT);
  assign end_lim   = CW'(end_i) * CW'(END_UNIT);
  assign armed     = en_i && (end_i != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      viol_q <= 1'b0;
    end else begin
      viol_q <= 1'b0;
      if (hold_i || !armed) begin
        cnt_q <= '0;
      end else if (kick_i) begin
        cnt_q  <= '0;
        viol_q <= (cnt_q < start_lim);  // kick before window opens
      end else if (tick_i) begin
        if (cnt_q == end_lim - CW'(1)) begin
          cnt_q  <= '0;
          viol_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign viol_o = viol_q;
endmodule

// File: rtl/sup_hold.sv
module sup_hold
  import sup_pkg::*;
#(
  parameter int HOLD_TICKS = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic supply_i,
  input  logic manual_i,
  input  logic wdt_i,
  input  logic flag_clr_i,
  output logic active_o,
  output logic wdt_flag_o
);
  localparam int HW = $clog2(HOLD_TICKS + 1);

  logic [HW-1:0] cnt_q;
  logic          flag_q;
  rst_cause_e    cause;

  always_comb begin
    if (wdt_i)         cause = CAUSE_WDT;
    else if (supply_i) cause = CAUSE_SUPPLY;
    else if (manual_i) cause = CAUSE_MANUAL;
    else               cause = CAUSE_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= HW'(HOLD_TICKS);
    end else if (cause != CAUSE_NONE) begin
      cnt_q <= HW'(HOLD_TICKS);
    end else if (tick_i && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
    end else begin
      case (cause)
        CAUSE_WDT:                  flag_q <= 1'b1;
        CAUSE_SUPPLY, CAUSE_MANUAL: flag_q <= 1'b0;
        default:                    if (flag_clr_i) flag_q <= 1'b0;
      endcase
    end
  end

  assign active_o   = (cnt_q != '0);
  assign wdt_flag_o = flag_q;
endmodule

// File: rtl/sup_reset_wdt.sv
module sup_reset_wdt #(
  parameter int HOLD_TICKS = 100,
  parameter int DEB_TICKS  = 10,
  parameter int START_UNIT = 25,
  parameter int END_UNIT   = 60,
  parameter int FIELD_W    = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               low_vdd_i,
  input  logic               man_rst_ni,
  input  logic               wdt_en_i,
  input  logic [FIELD_W-1:0] wdt_start_i,
  input  logic [FIELD_W-1:0] wdt_end_i,
  input  logic               kick_i,
  input  logic               flag_clr_i,
  output logic               sys_rst_no,
  output logic               wdt_flag_o
);
  logic man_act, wdt_viol, rst_active;

  sup_debounce #(.DEB_TICKS(DEB_TICKS), .SYNC_STAGES(2)) u_deb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .raw_ni (man_rst_ni),
    .act_o  (man_act)
  );

  sup_wdt #(.START_UNIT(START_UNIT), .END_UNIT(END_UNIT), .FIELD_W(FIELD_W)) u_wdt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .hold_i  (rst_active),
    .en_i    (wdt_en_i),
    .start_i (wdt_start_i),
    .end_i   (wdt_end_i),
    .kick_i  (kick_i),
    .viol_o  (wdt_viol)
  );

  sup_hold #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .supply_i   (low_vdd_i),
    .manual_i   (man_act),
    .wdt_i      (wdt_viol),
    .flag_clr_i (flag_clr_i),
    .active_o   (rst_active),
    .wdt_flag_o (wdt_flag_o)
  );

  assign sys_rst_no = ~rst_active;
endmodule

// File: rtl/sup_reset_wdt_chk.sv
module sup_reset_wdt_chk #(
  parameter int FIELD_W = 5
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               low_vdd_i,
  input logic               wdt_en_i,
  input logic [FIELD_W-1:0] wdt_end_i,
  input logic               flag_clr_i,
  input logic               wdt_viol,
  input logic               sys_rst_no,
  input logic               wdt_flag_o
);
  assert_supply_rst_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    low_vdd_i |=> !sys_rst_no);

  assert_wdt_rst_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_viol |=> !sys_rst_no);

  assert_disabled_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wdt_en_i || wdt_end_i == '0) |=> !wdt_viol);

  assert_flag_set_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_viol |=> wdt_flag_o);

  assert_flag_supply_clr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (low_vdd_i && !wdt_viol) |=> !wdt_flag_o);

  assert_flag_host_clr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_clr_i && !wdt_viol) |=> !wdt_flag_o);

  assert_no_viol_in_rst_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sys_rst_no |=> !wdt_viol);
endmodule

bind sup_reset_wdt sup_reset_wdt_chk #(.FIELD_W(FIELD_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .low_vdd_i  (low_vdd_i),
  .wdt_en_i   (wdt_en_i),
  .wdt_end_i  (wdt_end_i),
  .flag_clr_i (flag_clr_i),
  .wdt_viol   (wdt_viol),
  .sys_rst_no (sys_rst_no),
  .wdt_flag_o (wdt_flag_o)
);

// File: tb/sup_reset_wdt_tb_top.sv
`timescale 1ns/1ps
module sup_reset_wdt_tb_top;
  localparam int HOLD = 100;
  localparam int DEB  = 10;
  localparam int SU   = 25;
  localparam int EU   = 60;

  logic       clk = 1'b0, rst_n = 1'b0, tick = 1'b0, low_vdd = 1'b0, man_n = 1'b1;
  logic       en = 1'b0, kick = 1'b0, fclr = 1'b0;
  logic [4:0] st = '0, en_f = '0;
  logic       sys_rst_n, flag;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  sup_reset_wdt dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .low_vdd_i(low_vdd),
    .man_rst_ni(man_n), .wdt_en_i(en), .wdt_start_i(st), .wdt_end_i(en_f),
    .kick_i(kick), .flag_clr_i(fclr), .sys_rst_no(sys_rst_n), .wdt_flag_o(flag)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic run_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
  endtask

  task automatic do_kick();
    @(negedge clk) kick = 1'b1;
    @(negedge clk) kick = 1'b0;
    idle(3);
  endtask

  // force a fresh window via a supply pulse and the full hold
  task automatic fresh();
    @(negedge clk) low_vdd = 1'b1;
    idle(2);
    low_vdd = 1'b0;
    run_ticks(HOLD);
  endtask

  function automatic logic exp_rst(input int s, input int e, input int k);
    return (k < s * SU) || (k >= e * EU);
  endfunction

  initial begin
    #(20ns * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run hung");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    idle(3);
    rst_n = 1'b1;
    idle(2);
    chk("R1 reset state", sys_rst_n, 1'b0);
    chk("R1 flag at reset", flag, 1'b0);
    run_ticks(HOLD - 1);
    chk("R1 hold not done", sys_rst_n, 1'b0);
    run_ticks(1);
    chk("R1 released", sys_rst_n, 1'b1);

    // supply source and hold length
    @(negedge clk) low_vdd = 1'b1;
    idle(2);
    chk("R2 supply asserts", sys_rst_n, 1'b0);
    run_ticks(150);
    chk("R2 stays while low", sys_rst_n, 1'b0);
    low_vdd = 1'b0;
    run_ticks(HOLD - 1);
    chk("R3 still held", sys_rst_n, 1'b0);
    run_ticks(1);
    chk("R3 release", sys_rst_n, 1'b1);

    // manual: short glitch then full press
    man_n = 1'b0; idle(3);
    run_ticks(DEB - 1);
    man_n = 1'b1; idle(3);
    chk("R4 glitch ignored", sys_rst_n, 1'b1);
    man_n = 1'b0; idle(3);
    run_ticks(DEB);
    idle(2);
    chk("R4 press accepted", sys_rst_n, 1'b0);
    man_n = 1'b1; idle(3);
    run_ticks(HOLD);
    chk("R4 press release", sys_rst_n, 1'b1);

    // disabled cases
    en = 1'b0; en_f = 5'd1; st = '0;
    run_ticks(200);
    chk("R8 enable low", sys_rst_n, 1'b1);
    en = 1'b1; en_f = 5'd0;
    run_ticks(200);
    chk("R8 end field zero", sys_rst_n, 1'b1);

    // timeout edge
    en_f = 5'd1; st = 5'd0;
    fresh();
    run_ticks(EU - 1);
    chk("R5 before timeout", sys_rst_n, 1'b1);
    run_ticks(1); idle(2);
    chk("R5 timeout reset", sys_rst_n, 1'b0);
    chk("R9 flag set", flag, 1'b1);
    run_ticks(HOLD);
    chk("R10 released", sys_rst_n, 1'b1);
    run_ticks(EU - 1);
    chk("R10 full window", sys_rst_n, 1'b1);
    @(negedge clk) fclr = 1'b1;
    @(negedge clk) fclr = 1'b0;
    chk("R9 host clear", flag, 1'b0);
    run_ticks(1); idle(2);
    chk("R9 flag again", flag, 1'b1);
    run_ticks(HOLD);
    fresh();
    chk("R9 supply clears flag", flag, 1'b0);

    // early kick edge and valid kick restart
    st = 5'd2; en_f = 5'd2;
    fresh();
    run_ticks(2 * SU - 1);
    do_kick();
    chk("R6 early kick", sys_rst_n, 1'b0);
    fresh();
    run_ticks(2 * SU);
    do_kick();
    chk("R7 kick at open", sys_rst_n, 1'b1);
    run_ticks(2 * EU - 1);
    chk("R7 window restarted", sys_rst_n, 1'b1);
    do_kick();
    chk("R7 second kick", sys_rst_n, 1'b1);

    // random windows and kick times
    for (int t = 0; t < 24; t++) begin
      int s, e, k;
      logic ex;
      s = $urandom_range(0, 4);
      e = $urandom_range(1, 3);
      k = $urandom_range(0, e * EU + 5);
      st = 5'(s); en_f = 5'(e);
      fresh();
      run_ticks(k);
      do_kick();
      ex = exp_rst(s, e, k);
      chk("R5/R6/R7 random kick", sys_rst_n, ~ex);
      chk("R9 random flag", flag, ex);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule